// File: doc/BRIEF.md
# Address-Space-Tagged Translation Buffer with Selective Invalidation

This block is a small fully associative translation buffer. It holds recent virtual-page to physical-page translations. Every entry carries the identifier of the address space that installed it, plus a global flag. Because of these tags, several processes can keep translations in the buffer at the same time. On a context switch the incoming process simply presents its own identifier, and there is no need to empty the buffer.

A lookup is combinational against the registered entries. It takes a virtual page number and the current address-space identifier, and returns a hit flag, the physical page number and the permission bits. Refills come from outside through a fill port, which writes one entry per cycle. A control side provides the following operations:

- a full invalidation;
- an invalidation that spares global entries;
- a write to the page-table base register, which can also start an invalidation automatically.

Every invalidation only clears valid bits. The stored fields are left in place.

Top module: `asid_tlb`

## Requirements
- R1: After reset no entry is valid, every lookup reports a miss with zero physical page and zero permissions, and the base register reads 0.
- R2: A lookup hits when some valid entry has the queried virtual page and either an identifier equal to the current one or its global flag set. The hit returns that entry's physical page and permissions in the same cycle. A miss returns zeros.
- R3: Entries with the same virtual page and different identifiers coexist. Each identifier sees only its own translation.
- R4: An entry filled with its global flag set hits for every current identifier.
- R5: A full invalidation (`inv_all`) leaves no valid entry. Every later lookup misses until a refill.
- R6: A non-global invalidation (`inv_local`) clears every entry whose global flag is 0 and keeps every global entry valid.
- R7: With the default configuration, a base write (`ptb_we`) loads `ptb_wdata` into `ptb_q` at the clock edge and at the same time performs the non-global invalidation of R6.
- R8: Changing the current identifier invalidates nothing. A translation filled earlier hits again once its identifier returns.
- R9: The fill position is chosen in this order:
  - a valid entry with the same virtual page and identifier is overwritten;
  - otherwise the lowest-numbered invalid entry is used;
  - otherwise a rotating victim is used. It starts at entry 0 and advances by one, wrapping, after each such eviction.
  Two valid entries never share virtual page and identifier.
- R10: When an invalidation and a fill arrive in the same cycle, the invalidation is applied first and the new entry remains valid.
- R11: When several valid entries match a lookup, the lowest-numbered entry supplies the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cur_asid | input | ASID_W | Identifier of the running address space |
| lk_vpn | input | VPN_W | Virtual page number to translate |
| lk_hit | output | 1 | Lookup found a translation |
| lk_ppn | output | PPN_W | Physical page number of the hit, 0 on miss |
| lk_perm | output | PERM_W | Permission bits of the hit, 0 on miss |
| fill_en | input | 1 | Write one entry this cycle |
| fill_vpn | input | VPN_W | Virtual page of the new entry |
| fill_asid | input | ASID_W | Identifier of the new entry |
| fill_glb | input | 1 | Global flag of the new entry |
| fill_ppn | input | PPN_W | Physical page of the new entry |
| fill_perm | input | PERM_W | Permission bits of the new entry |
| inv_all | input | 1 | Invalidate every entry |
| inv_local | input | 1 | Invalidate every non-global entry |
| ptb_we | input | 1 | Write the page-table base register |
| ptb_wdata | input | PTB_W | New base register value |
| ptb_q | output | PTB_W | Current base register value |

## Verification
The tagging is exercised with directed patterns:
- one virtual page installed under two identifiers, which separates identifier matching from plain page matching;
- a global entry probed under an unrelated identifier;
- a global entry and a private entry on the same page, which exposes the lowest-index priority.

Each flush flavour is applied to a mix of global and private entries, so a full invalidation cannot be confused with a selective one. A base write is checked both for its register value and for its invalidation. A filled buffer followed by two further fills shows where the rotating victim stands and how it advances. A same-key refill shows that an overwrite is not mistaken for a new allocation. A long constrained-random run then uses a narrow page and identifier space, so collisions, overwrites, evictions and combined flush-plus-fill cycles all occur often. Every lookup in that run is compared against a bench model of the placement and matching rules.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  typedef enum logic [1:0] {
    PTB_NOFLUSH = 2'd0,
    PTB_FLUSH_ALL = 2'd1,
    PTB_FLUSH_LOCAL = 2'd2
  } ptb_flush_e;

  // next position of the rotating victim pointer, wrapping at n entries
  function automatic int unsigned rr_next(input int unsigned cur, input int unsigned n);
    return (cur + 1 >= n) ? 0 : cur + 1;
  endfunction
endpackage

// File: rtl/tlb_lookup.sv
module tlb_lookup #(
  parameter int N = 16,
  parameter int VPN_W = 20,
  parameter int ASID_W = 8,
  parameter int PPN_W = 20,
  parameter int PERM_W = 3,
  parameter bit TAG_ASID = 1'b1,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]             valid,
  input  logic [N-1:0]             glb,
  input  logic [N-1:0][VPN_W-1:0]  vpn,
  input  logic [N-1:0][ASID_W-1:0] asid,
  input  logic [N-1:0][PPN_W-1:0]  ppn,
  input  logic [N-1:0][PERM_W-1:0] perm,
  input  logic [VPN_W-1:0]         q_vpn,
  input  logic [ASID_W-1:0]        q_asid,
  output logic [N-1:0]             match_vec,
  output logic                     hit,
  output logic [IDX_W-1:0]         hit_idx,
  output logic [PPN_W-1:0]         hit_ppn,
  output logic [PERM_W-1:0]        hit_perm
);
  for (genvar i = 0; i < N; i++) begin : g_cmp
    logic asid_ok;
    assign asid_ok = glb[i] || !TAG_ASID || (asid[i] == q_asid);
    assign match_vec[i] = valid[i] && (vpn[i] == q_vpn) && asid_ok;
  end

  // lowest index wins: scan downward so the last assignment is the lowest
  always_comb begin
    hit_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (match_vec[i]) hit_idx = IDX_W'(i);
    end
  end

  assign hit      = |match_vec;
  assign hit_ppn  = hit ? ppn[hit_idx] : '0;
  assign hit_perm = hit ? perm[hit_idx] : '0;
endmodule

// File: rtl/tlb_flush_ctl.sv
module tlb_flush_ctl
  import tlb_pkg::*;
#(
  parameter int N = 16,
  parameter bit TAG_ASID = 1'b1,
  parameter ptb_flush_e PTB_MODE = PTB_FLUSH_LOCAL
) (
  input  logic         inv_all,
  input  logic         inv_local,
  input  logic         ptb_we,
  input  logic         asid_chg,
  input  logic [N-1:0] valid_q,
  input  logic [N-1:0] glb_q,
  output logic         kill_all,
  output logic         kill_local,
  output logic [N-1:0] valid_keep
);
  assign kill_all = inv_all
                  || (ptb_we && (PTB_MODE == PTB_FLUSH_ALL))
                  || (asid_chg && !TAG_ASID);
  assign kill_local = inv_local || (ptb_we && (PTB_MODE == PTB_FLUSH_LOCAL));

  always_comb begin
    if (kill_all)        valid_keep = '0;
    else if (kill_local) valid_keep = valid_q & glb_q;
    else                 valid_keep = valid_q;
  end
endmodule

// File: rtl/tlb_alloc.sv
module tlb_alloc #(
  parameter int N = 16,
  parameter int VPN_W = 20,
  parameter int ASID_W = 8,
  parameter bit TAG_ASID = 1'b1,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]             valid_keep,
  input  logic [N-1:0][VPN_W-1:0]  vpn,
  input  logic [N-1:0][ASID_W-1:0] asid,
  input  logic [VPN_W-1:0]         f_vpn,
  input  logic [ASID_W-1:0]        f_asid,
  input  logic [IDX_W-1:0]         rr_ptr,
  output logic [IDX_W-1:0]         way,
  output logic                     way_is_rr,
  output logic                     way_is_dup
);
  logic [N-1:0] same_key;
  logic [IDX_W-1:0] dup_idx, free_idx;
  logic any_free;

  for (genvar i = 0; i < N; i++) begin : g_key
    assign same_key[i] = valid_keep[i] && (vpn[i] == f_vpn)
                       && (!TAG_ASID || (asid[i] == f_asid));
  end

  always_comb begin
    dup_idx  = '0;
    free_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (same_key[i])    dup_idx  = IDX_W'(i);
      if (!valid_keep[i]) free_idx = IDX_W'(i);
    end
  end

  assign any_free   = ~&valid_keep;
  assign way_is_dup = |same_key;
  assign way_is_rr  = !way_is_dup && !any_free;
  assign way        = way_is_dup ? dup_idx : (any_free ? free_idx : rr_ptr);
endmodule

// File: rtl/asid_tlb.sv
module asid_tlb
  import tlb_pkg::*;
#(
  parameter int N = 16,
  parameter int VPN_W = 20,
  parameter int PPN_W = 20,
  parameter int ASID_W = 8,
  parameter int PERM_W = 3,
  parameter int PTB_W = 32,
  parameter bit TAG_ASID = 1'b1,
  parameter ptb_flush_e PTB_MODE = PTB_FLUSH_LOCAL,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ASID_W-1:0] cur_asid,
  input  logic [VPN_W-1:0]  lk_vpn,
  output logic              lk_hit,
  output logic [PPN_W-1:0]  lk_ppn,
  output logic [PERM_W-1:0] lk_perm,
  input  logic              fill_en,
  input  logic [VPN_W-1:0]  fill_vpn,
  input  logic [ASID_W-1:0] fill_asid,
  input  logic              fill_glb,
  input  logic [PPN_W-1:0]  fill_ppn,
  input  logic [PERM_W-1:0] fill_perm,
  input  logic              inv_all,
  input  logic              inv_local,
  input  logic              ptb_we,
  input  logic [PTB_W-1:0]  ptb_wdata,
  output logic [PTB_W-1:0]  ptb_q
);
  logic [N-1:0]             valid_q, glb_q, valid_keep, match_vec;
  logic [N-1:0][VPN_W-1:0]  vpn_q;
  logic [N-1:0][ASID_W-1:0] asid_q;
  logic [N-1:0][PPN_W-1:0]  ppn_q;
  logic [N-1:0][PERM_W-1:0] perm_q;
  logic [IDX_W-1:0]         rr_q, way, hit_idx;
  logic [ASID_W-1:0]        prev_asid_q;
  logic                     kill_all, kill_local, way_is_rr, way_is_dup, asid_chg;

  assign asid_chg = (cur_asid != prev_asid_q);

  tlb_lookup #(.N(N), .VPN_W(VPN_W), .ASID_W(ASID_W), .PPN_W(PPN_W),
               .PERM_W(PERM_W), .TAG_ASID(TAG_ASID)) u_lookup (
    .valid(valid_q), .glb(glb_q), .vpn(vpn_q), .asid(asid_q), .ppn(ppn_q),
    .perm(perm_q), .q_vpn(lk_vpn), .q_asid(cur_asid), .match_vec(match_vec),
    .hit(lk_hit), .hit_idx(hit_idx), .hit_ppn(lk_ppn), .hit_perm(lk_perm)
  );

  tlb_flush_ctl #(.N(N), .TAG_ASID(TAG_ASID), .PTB_MODE(PTB_MODE)) u_flush (
    .inv_all(inv_all), .inv_local(inv_local), .ptb_we(ptb_we),
    .asid_chg(asid_chg), .valid_q(valid_q), .glb_q(glb_q),
    .kill_all(kill_all), .kill_local(kill_local), .valid_keep(valid_keep)
  );

  tlb_alloc #(.N(N), .VPN_W(VPN_W), .ASID_W(ASID_W), .TAG_ASID(TAG_ASID)) u_alloc (
    .valid_keep(valid_keep), .vpn(vpn_q), .asid(asid_q), .f_vpn(fill_vpn),
    .f_asid(fill_asid), .rr_ptr(rr_q), .way(way), .way_is_rr(way_is_rr),
    .way_is_dup(way_is_dup)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q     <= '0;
      rr_q        <= '0;
      ptb_q       <= '0;
      prev_asid_q <= '0;
    end else begin
      valid_q     <= valid_keep | (fill_en ? (N'(1) << way) : '0);
      prev_asid_q <= cur_asid;
      if (ptb_we) ptb_q <= ptb_wdata;
      if (fill_en && way_is_rr) rr_q <= IDX_W'(rr_next(int'(rr_q), N));
    end
  end

  // payload fields: invalidation never erases them, only the valid bits
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      glb_q  <= '0;
      vpn_q  <= '0;
      asid_q <= '0;
      ppn_q  <= '0;
      perm_q <= '0;
    end else if (fill_en) begin
      glb_q[way]  <= fill_glb;
      vpn_q[way]  <= fill_vpn;
      asid_q[way] <= fill_asid;
      ppn_q[way]  <= fill_ppn;
      perm_q[way] <= fill_perm;
    end
  end
endmodule

// File: rtl/tlb_checker.sv
module tlb_checker
  import tlb_pkg::*;
#(
  parameter int N = 16,
  parameter int VPN_W = 20,
  parameter int ASID_W = 8,
  parameter bit TAG_ASID = 1'b1,
  parameter ptb_flush_e PTB_MODE = PTB_FLUSH_LOCAL
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     inv_all,
  input logic                     inv_local,
  input logic                     ptb_we,
  input logic                     fill_en,
  input logic                     lk_hit,
  input logic [N-1:0]             valid_q,
  input logic [N-1:0]             glb_q,
  input logic [N-1:0][VPN_W-1:0]  vpn_q,
  input logic [N-1:0][ASID_W-1:0] asid_q
);
  logic dup;
  always_comb begin
    dup = 1'b0;
    for (int i = 0; i < N; i++)
      for (int j = i + 1; j < N; j++)
        if (valid_q[i] && valid_q[j] && vpn_q[i] == vpn_q[j]
            && (!TAG_ASID || asid_q[i] == asid_q[j]))
          dup = 1'b1;
  end

  a_r9_no_duplicate: assert property (@(posedge clk) disable iff (!rst_n) !dup);

  a_r1_empty_misses: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q == '0) |-> !lk_hit);

  a_r5_full_flush: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_all && !fill_en) |=> (valid_q == '0));

  a_r10_flush_then_fill: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_all && fill_en) |=> ($countones(valid_q) == 1));

  a_r6_local_keeps_global: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_local && !inv_all && !ptb_we && !fill_en) |=> (valid_q == $past(valid_q & glb_q)));

  if (PTB_MODE == PTB_FLUSH_LOCAL) begin : g_ptb
    a_r7_base_write_flush: assert property (@(posedge clk) disable iff (!rst_n)
      (ptb_we && !fill_en) |=> ((valid_q & ~glb_q) == '0));
  end

  if (TAG_ASID) begin : g_tag
    a_r8_no_silent_invalidate: assert property (@(posedge clk) disable iff (!rst_n)
      (!inv_all && !inv_local && !ptb_we) |=> (($past(valid_q) & ~valid_q) == '0));
  end
endmodule

bind asid_tlb tlb_checker #(
  .N(N), .VPN_W(VPN_W), .ASID_W(ASID_W), .TAG_ASID(TAG_ASID), .PTB_MODE(PTB_MODE)
) u_tlb_checker (
  .clk(clk), .rst_n(rst_n), .inv_all(inv_all), .inv_local(inv_local),
  .ptb_we(ptb_we), .fill_en(fill_en), .lk_hit(lk_hit), .valid_q(valid_q),
  .glb_q(glb_q), .vpn_q(vpn_q), .asid_q(asid_q)
);

// File: tb/asid_tlb_bench.sv
module asid_tlb_bench;
  localparam int CLK_PERIOD = 10;
  localparam int N = 16;
  localparam int VW = 20, PW = 20, AW = 8, MW = 3, BW = 32;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [AW-1:0] cur_asid = '0;
  logic [VW-1:0] lk_vpn = '0;
  logic lk_hit;
  logic [PW-1:0] lk_ppn;
  logic [MW-1:0] lk_perm;
  logic fill_en = 0, fill_glb = 0, inv_all = 0, inv_local = 0, ptb_we = 0;
  logic [VW-1:0] fill_vpn = '0;
  logic [AW-1:0] fill_asid = '0;
  logic [PW-1:0] fill_ppn = '0;
  logic [MW-1:0] fill_perm = '0;
  logic [BW-1:0] ptb_wdata = '0, ptb_q;

  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  asid_tlb u_asid_tlb (
    .clk(clk), .rst_n(rst_n), .cur_asid(cur_asid), .lk_vpn(lk_vpn),
    .lk_hit(lk_hit), .lk_ppn(lk_ppn), .lk_perm(lk_perm), .fill_en(fill_en),
    .fill_vpn(fill_vpn), .fill_asid(fill_asid), .fill_glb(fill_glb),
    .fill_ppn(fill_ppn), .fill_perm(fill_perm), .inv_all(inv_all),
    .inv_local(inv_local), .ptb_we(ptb_we), .ptb_wdata(ptb_wdata), .ptb_q(ptb_q)
  );

  // reference model built from the requirements
  bit            m_v[N];
  bit            m_g[N];
  logic [VW-1:0] m_vpn[N];
  logic [AW-1:0] m_as[N];
  logic [PW-1:0] m_ppn[N];
  logic [MW-1:0] m_pm[N];
  int            m_rr = 0;

  function automatic bit m_lookup(input logic [VW-1:0] v, input logic [AW-1:0] a,
                                  output logic [PW-1:0] p, output logic [MW-1:0] pm);
    p = '0; pm = '0;
    for (int i = 0; i < N; i++)
      if (m_v[i] && m_vpn[i] == v && (m_g[i] || m_as[i] == a)) begin
        p = m_ppn[i]; pm = m_pm[i];
        return 1'b1;
      end
    return 1'b0;
  endfunction

  function automatic int m_pick(input logic [VW-1:0] v, input logic [AW-1:0] a);
    for (int i = 0; i < N; i++) if (m_v[i] && m_vpn[i] == v && m_as[i] == a) return i;
    for (int i = 0; i < N; i++) if (!m_v[i]) return i;
    return -1;
  endfunction

  task automatic model_step();
    int w;
    if (inv_all) for (int i = 0; i < N; i++) m_v[i] = 0;
    else if (inv_local || ptb_we) for (int i = 0; i < N; i++) if (!m_g[i]) m_v[i] = 0;
    if (fill_en) begin
      w = m_pick(fill_vpn, fill_asid);
      if (w < 0) begin w = m_rr; m_rr = (m_rr + 1) % N; end
      m_v[w] = 1; m_g[w] = fill_glb; m_vpn[w] = fill_vpn; m_as[w] = fill_asid;
      m_ppn[w] = fill_ppn; m_pm[w] = fill_perm;
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    model_step();
    @(negedge clk);
    fill_en = 0; inv_all = 0; inv_local = 0; ptb_we = 0;
  endtask

  task automatic fill(input logic [VW-1:0] v, input logic [AW-1:0] a, input bit g,
                      input logic [PW-1:0] p, input logic [MW-1:0] pm);
    fill_en = 1; fill_vpn = v; fill_asid = a; fill_glb = g; fill_ppn = p; fill_perm = pm;
    cyc();
  endtask

  task automatic check(input string req, input logic [VW-1:0] v, input logic [AW-1:0] a,
                       input bit eh, input logic [PW-1:0] ep, input logic [MW-1:0] em);
    lk_vpn = v; cur_asid = a;
    #1;
    checks++;
    if (lk_hit !== eh || lk_ppn !== ep || lk_perm !== em) begin
      errors++;
      $display("FAIL %s vpn=%h asid=%h: hit=%b ppn=%h perm=%h expected hit=%b ppn=%h perm=%h",
               req, v, a, lk_hit, lk_ppn, lk_perm, eh, ep, em);
    end
  endtask

  task automatic check_model(input string req, input logic [VW-1:0] v, input logic [AW-1:0] a);
    logic [PW-1:0] p; logic [MW-1:0] pm; bit h;
    h = m_lookup(v, a, p, pm);
    check(req, v, a, h, p, pm);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: run did not complete, actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    for (int i = 0; i < N; i++) m_v[i] = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", 20'h10, 8'd1, 0, '0, '0);
    checks++;
    if (ptb_q !== '0) begin errors++; $display("FAIL R1 ptb_q=%h expected 0", ptb_q); end
    rst_n = 1;
    @(negedge clk);
    check("R1", 20'h0, 8'd0, 0, '0, '0);

    // R2 / R3: same page under two identifiers
    fill(20'h10, 8'd1, 0, 20'hAAAA1, 3'd5);
    fill(20'h10, 8'd2, 0, 20'hBBBB2, 3'd3);
    check("R2", 20'h10, 8'd1, 1, 20'hAAAA1, 3'd5);
    check("R3", 20'h10, 8'd2, 1, 20'hBBBB2, 3'd3);
    check("R2", 20'h10, 8'd3, 0, '0, '0);
    check("R2", 20'h11, 8'd1, 0, '0, '0);

    // R8: identifier changes across clock edges invalidate nothing
    cur_asid = 8'd7; cyc();
    cur_asid = 8'd9; cyc();
    check("R8", 20'h10, 8'd1, 1, 20'hAAAA1, 3'd5);
    cyc();
    check("R8", 20'h10, 8'd2, 1, 20'hBBBB2, 3'd3);

    // R4: global entry hits under any identifier
    fill(20'h20, 8'd5, 1, 20'hCCCC3, 3'd1);
    check("R4", 20'h20, 8'd9, 1, 20'hCCCC3, 3'd1);
    check("R4", 20'h20, 8'd5, 1, 20'hCCCC3, 3'd1);

    // R6: non-global invalidation
    inv_local = 1; cyc();
    check("R6", 20'h10, 8'd1, 0, '0, '0);
    check("R6", 20'h20, 8'd0, 1, 20'hCCCC3, 3'd1);

    // R7: base write loads register and invalidates private entries
    fill(20'h10, 8'd1, 0, 20'hAAAA1, 3'd5);
    check("R7", 20'h10, 8'd1, 1, 20'hAAAA1, 3'd5);
    ptb_we = 1; ptb_wdata = 32'h0001_2340; cyc();
    checks++;
    if (ptb_q !== 32'h0001_2340) begin
      errors++; $display("FAIL R7 ptb_q=%h expected 00012340", ptb_q);
    end
    check("R7", 20'h10, 8'd1, 0, '0, '0);
    check("R7", 20'h20, 8'd1, 1, 20'hCCCC3, 3'd1);

    // R5: full invalidation removes global entries as well
    inv_all = 1; cyc();
    check("R5", 20'h20, 8'd1, 0, '0, '0);

    // R9: same-key refill overwrites in place
    fill(20'h30, 8'd1, 0, 20'h0D0D0, 3'd2);
    fill(20'h30, 8'd1, 0, 20'h0E0E0, 3'd4);
    check("R9", 20'h30, 8'd1, 1, 20'h0E0E0, 3'd4);
    // R9: rotating victim after the buffer fills up
    inv_all = 1; cyc();
    for (int i = 0; i < N; i++) fill(20'h100 + VW'(i), 8'd3, 0, 20'h50000 + PW'(i), 3'd7);
    check("R9", 20'h10F, 8'd3, 1, 20'h5000F, 3'd7);
    fill(20'h200, 8'd3, 0, 20'h60000, 3'd6);
    check("R9", 20'h100, 8'd3, 0, '0, '0);
    check("R9", 20'h101, 8'd3, 1, 20'h50001, 3'd7);
    fill(20'h201, 8'd3, 0, 20'h60001, 3'd6);
    check("R9", 20'h101, 8'd3, 0, '0, '0);
    check("R9", 20'h200, 8'd3, 1, 20'h60000, 3'd6);

    // R10: invalidation and fill in one cycle
    inv_all = 1;
    fill(20'h300, 8'd4, 0, 20'h77777, 3'd1);
    check("R10", 20'h300, 8'd4, 1, 20'h77777, 3'd1);
    check("R10", 20'h200, 8'd3, 0, '0, '0);

    // R11: lowest index wins among overlapping matches
    inv_all = 1; cyc();
    fill(20'h40, 8'd1, 1, 20'h11111, 3'd1);
    fill(20'h40, 8'd2, 0, 20'h22222, 3'd2);
    check("R11", 20'h40, 8'd2, 1, 20'h11111, 3'd1);

    // constrained random against the model: R2 R3 R4 R5 R6 R7 R9 R10
    begin
      int unsigned seed, r;
      seed = 32'd12345;
      r = $urandom(seed);
      for (int k = 0; k < 3000; k++) begin
        r = $urandom % 100;
        inv_all   = (r < 2);
        inv_local = (r >= 2 && r < 5);
        ptb_we    = (r >= 5 && r < 7);
        ptb_wdata = $urandom;
        fill_en   = ($urandom % 100) < 60;
        fill_vpn  = VW'($urandom % 24);
        fill_asid = AW'($urandom % 4);
        fill_glb  = ($urandom % 8) == 0;
        fill_ppn  = PW'($urandom);
        fill_perm = MW'($urandom);
        cyc();
        check_model("R9", VW'($urandom % 24), AW'($urandom % 4));
      end
    end
    finish_run();
  end
endmodule